// File: doc/BRIEF.md
# Hamming SEC/DED Codec (4 data bits, 8-bit codeword)

This block pairs an encoder and a decoder for a single-error-correcting, double-error-detecting code over four data bits. The encoder turns a 4-bit data word into an 8-bit codeword. Three check bits are computed by parity equations over the data. One more bit, the overall parity, makes the XOR of the whole codeword zero. The decoder takes an 8-bit word that may be corrupted. It returns the recovered data, a single-error flag and a double-error flag.

The codeword is laid out by position. Bit i of the codeword vector is position i. The three-bit syndrome, read as a binary number, is therefore the index of the bit that flipped, and a plain 3-to-8 decode of the syndrome produces the correction mask. Position 0 holds the overall parity bit. Its check row is all ones, and it makes the code distance four.

Encoder and decoder each register their outputs on one clock edge. They are independent, so both can be used in the same cycle, for example on the write and read sides of a protected store.

Top module: `secded_codec`

## Requirements
- R1: Encoder layout. Codeword bit 1 is c0 = d2^d1^d0, bit 2 is c1 = d3^d1^d0, bit 4 is c2 = d3^d2^d1. Bit 3 holds d0, bit 5 holds d2, bit 6 holds d3 and bit 7 holds d1, where d3..d0 are bits 3..0 of the data input.
- R2: Encoder bit 0 is chosen so that the XOR of all eight codeword bits is 0.
- R3: Both outputs appear one clock after their inputs and change every cycle. While reset is low, the codeword, data and flag outputs are all 0.
- R4: The decoder forms a 3-bit syndrome. It is the XOR of the position numbers (1 to 7) of the bits that are 1, so any single flipped bit at position 1 to 7 gives a syndrome equal to that position. The decoder also forms an overall check, the XOR of all eight bits.
- R5: When the overall check is 1 and the syndrome is nonzero, the bit at the syndrome position is inverted before the data is extracted. The single-error flag is 1 and the double-error flag is 0, and the output data equals the data originally encoded.
- R6: When the overall check is 1 and the syndrome is 0, only the overall parity bit was hit. The data comes out unaltered and the single-error flag is 1.
- R7: When the overall check is 0 and the syndrome is nonzero, the double-error flag is 1 and the single-error flag is 0. The data output is the received data bits, taken from positions 6, 5, 7, 3 as d3..d0, with no bit inverted.
- R8: A valid codeword gives both flags 0 and data equal to the encoded data.
- R9: The single-error and double-error flags are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_data_i | input | 4 | Data word to encode |
| enc_cw_o | output | 8 | Registered codeword, bit i at position i |
| dec_cw_i | input | 8 | Received codeword to check |
| dec_data_o | output | 4 | Registered recovered data |
| dec_single_o | output | 1 | Registered single-error (corrected) flag |
| dec_double_o | output | 1 | Registered double-error (uncorrectable) flag |

## Verification
The bench encodes every data value. It then flips each of the eight bits of every codeword in turn, including the overall parity bit alone. A decoder that treated a zero syndrome as "no error" would drop the single flag there, and one that decoded position 0 as a data bit would corrupt the output. Every pair of bit flips is also applied. In many of those pairs the syndrome points at an innocent data position, and a decoder that corrects on a nonzero syndrome alone would silently return wrong data instead of raising the double flag. A back-to-back stream then checks that each result lands exactly one cycle after its input. If a position were misassigned in the layout, the encoded values would mismatch the bench's independent parity equations.

// File: rtl/secded_pkg.sv
package secded_pkg;

    // Number of position-indexed check bits; the codeword covers positions 0..2^SYN_W-1.
    localparam int SYN_W  = 3;
    localparam int CW_W   = 1 << SYN_W;
    localparam int DATA_W = CW_W - 1 - SYN_W;

    typedef logic [SYN_W-1:0]  syn_t;
    typedef logic [CW_W-1:0]   cw_t;
    typedef logic [DATA_W-1:0] data_t;

    // Codeword position that carries data bit idx.
    function automatic int data_pos(input int idx);
        case (idx)
            0:       return 3;
            1:       return 7;
            2:       return 5;
            3:       return 6;
            default: return 0;
        endcase
    endfunction

    // Mask of positions covered by check row j (positions whose index has bit j set).
    function automatic cw_t row_mask(input int j);
        cw_t m;
        m = '0;
        for (int p = 1; p < CW_W; p++) begin
            m[p] = ((p >> j) & 1) != 0;
        end
        return m;
    endfunction

    // Place data bits at their positions, zeros elsewhere.
    function automatic cw_t place_data(input data_t d);
        cw_t w;
        w = '0;
        for (int i = 0; i < DATA_W; i++) begin
            w[data_pos(i)] = d[i];
        end
        return w;
    endfunction

    // Extract data bits from their positions.
    function automatic data_t pick_data(input cw_t w);
        data_t d;
        for (int i = 0; i < DATA_W; i++) begin
            d[i] = w[data_pos(i)];
        end
        return d;
    endfunction

endpackage

// File: rtl/secded_syndrome.sv
module secded_syndrome
    import secded_pkg::*;
(
    input  cw_t  cw_i,
    output syn_t syn_o,
    output logic overall_o
);

    // One XOR tree per check row; the row masks give the position weighting.
    for (genvar j = 0; j < SYN_W; j++) begin : g_row
        localparam cw_t MASK = row_mask(j);
        assign syn_o[j] = ^(cw_i & MASK);
    end

    // All-ones row: parity over the whole word.
    assign overall_o = ^cw_i;

endmodule

// File: rtl/secded_encoder.sv
module secded_encoder
    import secded_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  data_t data_i,
    output cw_t   cw_o
);

    typedef struct packed {
        cw_t cw;
    } enc_state_t;

    enc_state_t st_d, st_q;
    cw_t        placed;
    syn_t       checks;

    assign placed = place_data(data_i);

    // Each check bit sits at position 2^j and covers its row of the placed data.
    for (genvar j = 0; j < SYN_W; j++) begin : g_chk
        localparam cw_t MASK = row_mask(j);
        assign checks[j] = ^(placed & MASK);
    end

    always_comb begin
        st_d.cw = placed;
        for (int j = 0; j < SYN_W; j++) begin
            st_d.cw[1 << j] = checks[j];
        end
        st_d.cw[0] = ^st_d.cw[CW_W-1:1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cw_o = st_q.cw;

    // Checks: armed once an edge has passed out of reset.
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
        end
    end

    a_r1_data_placed: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (pick_data(cw_o) == $past(data_i)));

    a_r2_even_weight: assert property (@(posedge clk) disable iff (!rst_n)
        (^cw_o) == 1'b0);

endmodule

// File: rtl/secded_decoder.sv
module secded_decoder
    import secded_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  cw_t   cw_i,
    output data_t data_o,
    output logic  single_o,
    output logic  double_o
);

    typedef struct packed {
        data_t data;
        logic  single;
        logic  double;
    } dec_state_t;

    dec_state_t st_d, st_q;
    syn_t       syn;
    logic       overall;
    cw_t        flip;

    secded_syndrome u_syn (
        .cw_i      (cw_i),
        .syn_o     (syn),
        .overall_o (overall)
    );

    // Position decoder: syndrome value names the bit to invert; position 0 needs no data fix.
    assign flip[0] = 1'b0;
    for (genvar p = 1; p < CW_W; p++) begin : g_flip
        assign flip[p] = overall && (syn == syn_t'(p));
    end

    always_comb begin
        st_d.data   = pick_data(cw_i ^ flip);
        st_d.single = overall;
        st_d.double = !overall && (syn != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o   = st_q.data;
    assign single_o = st_q.single;
    assign double_o = st_q.double;

    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
        end
    end

    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({single_o, double_o}));

    a_r5_single_odd: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && single_o) |-> (^$past(cw_i)) == 1'b1);

    a_r7_double_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && double_o) |-> (data_o == pick_data($past(cw_i))));

    a_r8_clean_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !single_o && !double_o) |->
            ((data_o == pick_data($past(cw_i))) && ((^$past(cw_i)) == 1'b0)));

endmodule

// File: rtl/secded_codec.sv
module secded_codec
    import secded_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DATA_W-1:0]    enc_data_i,
    output logic [CW_W-1:0]      enc_cw_o,
    input  logic [CW_W-1:0]      dec_cw_i,
    output logic [DATA_W-1:0]    dec_data_o,
    output logic                 dec_single_o,
    output logic                 dec_double_o
);

    secded_encoder u_enc (
        .clk    (clk),
        .rst_n  (rst_n),
        .data_i (enc_data_i),
        .cw_o   (enc_cw_o)
    );

    secded_decoder u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .cw_i     (dec_cw_i),
        .data_o   (dec_data_o),
        .single_o (dec_single_o),
        .double_o (dec_double_o)
    );

endmodule

// File: tb/tb_secded_codec.sv
module tb_secded_codec;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] enc_data;
    logic [7:0] enc_cw;
    logic [7:0] dec_cw;
    logic [3:0] dec_data;
    logic       dec_single;
    logic       dec_double;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    secded_codec dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enc_data_i   (enc_data),
        .enc_cw_o     (enc_cw),
        .dec_cw_i     (dec_cw),
        .dec_data_o   (dec_data),
        .dec_single_o (dec_single),
        .dec_double_o (dec_double)
    );

    // Reference encoding from the parity equations and the position layout.
    function automatic logic [7:0] ref_enc(input logic [3:0] d);
        logic c0, c1, c2;
        logic [7:0] w;
        c2 = d[3] ^ d[2] ^ d[1];
        c1 = d[3] ^ d[1] ^ d[0];
        c0 = d[2] ^ d[1] ^ d[0];
        w  = {d[1], d[3], d[2], c2, d[0], c1, c0, 1'b0};
        w[0] = ^w[7:1];
        return w;
    endfunction

    function automatic logic [3:0] raw_data(input logic [7:0] w);
        return {w[6], w[5], w[7], w[3]};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_dec(input string req, input logic [3:0] exp_data,
                             input logic exp_s, input logic exp_d);
        check(req, "data", 32'(dec_data), 32'(exp_data));
        check(req, "single", 32'(dec_single), 32'(exp_s));
        check(req, "double", 32'(dec_double), 32'(exp_d));
        check("R9", "flags exclusive", 32'(dec_single & dec_double), 32'd0);
    endtask

    task automatic decode_one(input string req, input logic [7:0] w,
                              input logic [3:0] exp_data, input logic exp_s, input logic exp_d);
        @(negedge clk);
        dec_cw = w;
        @(negedge clk);
        check_dec(req, exp_data, exp_s, exp_d);
    endtask

    // R3: outputs held at zero during reset even with active inputs.
    task automatic test_reset();
        rst_n    = 1'b0;
        enc_data = 4'hF;
        dec_cw   = 8'h01;
        repeat (3) @(negedge clk);
        check("R3", "reset codeword", 32'(enc_cw), 32'd0);
        check_dec("R3", 4'h0, 1'b0, 1'b0);
        rst_n = 1'b1;
    endtask

    // R1, R2: every data value.
    task automatic test_encode();
        for (int d = 0; d < 16; d++) begin
            @(negedge clk);
            enc_data = 4'(d);
            @(negedge clk);
            check("R1", "codeword", 32'(enc_cw), 32'(ref_enc(4'(d))));
            check("R2", "overall parity", 32'(^enc_cw), 32'd0);
        end
    endtask

    // R8: clean codewords.
    task automatic test_clean();
        for (int d = 0; d < 16; d++) begin
            decode_one("R8", ref_enc(4'(d)), 4'(d), 1'b0, 1'b0);
        end
    endtask

    // R4, R5, R6: each single flip of each codeword.
    task automatic test_single();
        for (int d = 0; d < 16; d++) begin
            for (int b = 0; b < 8; b++) begin
                logic [7:0] w;
                w = ref_enc(4'(d)) ^ (8'd1 << b);
                if (b == 0) decode_one("R6", w, 4'(d), 1'b1, 1'b0);
                else        decode_one("R5", w, 4'(d), 1'b1, 1'b0);
            end
        end
    endtask

    // R7: every pair of flips; data must be the raw received bits.
    task automatic test_double();
        for (int d = 0; d < 16; d++) begin
            for (int a = 0; a < 8; a++) begin
                for (int b = a + 1; b < 8; b++) begin
                    logic [7:0] w;
                    w = ref_enc(4'(d)) ^ (8'd1 << a) ^ (8'd1 << b);
                    decode_one("R7", w, raw_data(w), 1'b0, 1'b1);
                end
            end
        end
    endtask

    // R3, R4: back-to-back inputs, each result one cycle later.
    task automatic test_stream();
        logic [3:0] prev_d;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (i > 0) begin
                check("R3", "stream codeword", 32'(enc_cw), 32'(ref_enc(prev_d)));
                check_dec("R4", prev_d, 1'b1, 1'b0);
            end
            prev_d   = 4'((i * 7 + 3) % 16);
            enc_data = prev_d;
            dec_cw   = ref_enc(prev_d) ^ (8'd1 << (i % 8));
        end
        @(negedge clk);
        check("R3", "stream codeword", 32'(enc_cw), 32'(ref_enc(prev_d)));
        check_dec("R4", prev_d, 1'b1, 1'b0);
    endtask

    initial begin
        test_reset();
        test_encode();
        test_clean();
        test_single();
        test_double();
        test_stream();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule